// File: doc/BRIEF.md
# Ternary Logic Unit with Write-Masking

This block evaluates one of the 256 possible three-input boolean functions across three 512-bit operands in a single pass. An 8-bit immediate is read as a truth table: for every bit position, the bits of the three operands form a 3-bit index, and the immediate bit at that index becomes the result bit. No bit position depends on any other position.

The wide result is then treated as a row of lanes, either sixteen 32-bit lanes or eight 64-bit lanes, and a per-lane write mask decides which lanes take the new value. A disabled lane either keeps its previous destination contents (merge) or is cleared (zero). A bypass flag writes every lane whatever the mask holds. The result is registered, so it appears one cycle after the request.

Top module: `tlu_top`

## Requirements
- R1: Each result bit at position k equals imm8[{a[k], b[k], c[k]}], where a[k] is the most significant index bit and c[k] the least significant.
- R2: Each result bit depends only on the bits at the same position k in a, b and c, so any operand pattern produces the truth-table function at every position.
- R3: With imm8 = 8'hCA and every lane written, the result equals (a & b) | (~a & c), a bit select in which a acts as the selector.
- R4: When no_mask is 1, every bit of the result is the truth-table value, whatever wmask and elem_wide hold.
- R5: With elem_wide = 0 and no_mask = 0, wmask bit i enables lane bits [32i+31:32i].
- R6: With elem_wide = 1 and no_mask = 0, wmask bit j enables bits [64j+63:64j] for j in 0..7, and wmask bits [15:8] have no effect on the result.
- R7: With zero_mode = 0, a lane whose enable is 0 takes its bits from dst_old.
- R8: With zero_mode = 1, a lane whose enable is 0 is cleared to all zeros.
- R9: out_valid is 1 exactly in the cycle after a cycle in which in_valid was 1, and out_data carries that request's result in the same cycle.
- R10: While in_valid is 0, out_data keeps its last value.
- R11: After reset, out_valid is 0 and out_data is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| imm8 | input | 8 | Truth table of the boolean function |
| src_a | input | 512 | First operand (most significant index bit) |
| src_b | input | 512 | Second operand |
| src_c | input | 512 | Third operand (least significant index bit) |
| dst_old | input | 512 | Prior destination contents used for merge |
| wmask | input | 16 | Per-lane write enables |
| elem_wide | input | 1 | Lane size: 0 for 32-bit, 1 for 64-bit |
| zero_mode | input | 1 | 0 keeps disabled lanes, 1 clears them |
| no_mask | input | 1 | 1 writes every lane regardless of wmask |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 512 | Registered result |

## Verification
The bench builds the block with its default parameters: a 512-bit datapath and 32-bit narrow lanes, giving a 16-bit mask and eight 64-bit wide lanes. At that width the upper mask byte is live in narrow mode but dead in wide mode, so the test that wide lanes ignore it is meaningful, and every one of the 256 immediates can be swept across independent per-position operand bits. Directed cases cover the 8'hCA select, an all-upper-byte mask in wide mode, a zero mask under the bypass flag and the hold behaviour; random operands, masks and modes fill the rest.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

  // One truth-table lookup: a is the high index bit, c the low one.
  function automatic logic tlu_lookup(input logic [7:0] table_bits,
                                      input logic       bit_a,
                                      input logic       bit_b,
                                      input logic       bit_c);
    logic [2:0] idx;
    idx = {bit_a, bit_b, bit_c};
    return table_bits[idx];
  endfunction

  // Lane output: written lanes take the new value, others merge or clear.
  function automatic logic tlu_lane_bit(input logic enable,
                                        input logic new_bit,
                                        input logic old_bit,
                                        input logic clear_off);
    if (enable)    return new_bit;
    if (clear_off) return 1'b0;
    return old_bit;
  endfunction

endpackage

// File: rtl/tlu_truth_array.sv
module tlu_truth_array #(
  parameter int DATA_W = 512
) (
  input  logic [7:0]        imm8,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  output logic [DATA_W-1:0] raw_bits
);
  import tlu_pkg::*;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign raw_bits[k] = tlu_lookup(imm8, src_a[k], src_b[k], src_c[k]);
  end

endmodule

// File: rtl/tlu_mask_expand.sv
module tlu_mask_expand #(
  parameter int DATA_W = 512,
  parameter int LANE_W = 32,
  localparam int MASK_W = DATA_W / LANE_W
) (
  input  logic [MASK_W-1:0] wmask,
  input  logic              elem_wide,
  input  logic              no_mask,
  output logic [MASK_W-1:0] lane_en,
  output logic [DATA_W-1:0] en_bits
);

  // Each narrow lane j draws its enable from mask bit j, or from bit j/2
  // when two narrow lanes form one wide lane.
  for (genvar j = 0; j < MASK_W; j++) begin : g_lane
    localparam int WIDE_IDX = j / 2;
    logic sel_bit;
    assign sel_bit    = elem_wide ? wmask[WIDE_IDX] : wmask[j];
    assign lane_en[j] = no_mask | sel_bit;
    assign en_bits[j*LANE_W +: LANE_W] = {LANE_W{lane_en[j]}};
  end

endmodule

// File: rtl/tlu_lane_apply.sv
module tlu_lane_apply #(
  parameter int DATA_W = 512
) (
  input  logic [DATA_W-1:0] raw_bits,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [DATA_W-1:0] en_bits,
  input  logic              zero_mode,
  output logic [DATA_W-1:0] next_bits
);
  import tlu_pkg::*;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    assign next_bits[k] = tlu_lane_bit(en_bits[k], raw_bits[k],
                                       dst_old[k], zero_mode);
  end

endmodule

// File: rtl/tlu_top.sv
module tlu_top #(
  parameter int DATA_W = 512,
  parameter int LANE_W = 32,
  localparam int MASK_W = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        imm8,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [MASK_W-1:0] wmask,
  input  logic              elem_wide,
  input  logic              zero_mode,
  input  logic              no_mask,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] raw_bits;
  logic [DATA_W-1:0] en_bits;
  logic [MASK_W-1:0] lane_en;
  logic [DATA_W-1:0] next_bits;

  tlu_truth_array #(.DATA_W(DATA_W)) u_truth (
    .imm8     (imm8),
    .src_a    (src_a),
    .src_b    (src_b),
    .src_c    (src_c),
    .raw_bits (raw_bits)
  );

  tlu_mask_expand #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_expand (
    .wmask     (wmask),
    .elem_wide (elem_wide),
    .no_mask   (no_mask),
    .lane_en   (lane_en),
    .en_bits   (en_bits)
  );

  tlu_lane_apply #(.DATA_W(DATA_W)) u_apply (
    .raw_bits  (raw_bits),
    .dst_old   (dst_old),
    .en_bits   (en_bits),
    .zero_mode (zero_mode),
    .next_bits (next_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_bits;
    end
  end

endmodule

// File: rtl/tlu_chk.sv
module tlu_chk #(
  parameter int DATA_W = 512,
  parameter int LANE_W = 32,
  localparam int MASK_W = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] dst_old,
  input logic [MASK_W-1:0] wmask,
  input logic              elem_wide,
  input logic              zero_mode,
  input logic              no_mask,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W-1:0] raw_bits,
  input logic [DATA_W-1:0] en_bits
);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  a_r4_bypass_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && no_mask) |=> (out_data == $past(raw_bits)));

  a_r8_zero_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !no_mask && zero_mode && !elem_wide && !wmask[0])
      |=> (out_data[LANE_W-1:0] == '0));

  a_r7_merge_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !no_mask && !zero_mode && !elem_wide && !wmask[0])
      |=> (out_data[LANE_W-1:0] == $past(dst_old[LANE_W-1:0])));

  a_r6_wide_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_wide && !no_mask) |-> (en_bits[LANE_W] == wmask[0]));

endmodule

bind tlu_top tlu_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .dst_old   (dst_old),
  .wmask     (wmask),
  .elem_wide (elem_wide),
  .zero_mode (zero_mode),
  .no_mask   (no_mask),
  .out_valid (out_valid),
  .out_data  (out_data),
  .raw_bits  (raw_bits),
  .en_bits   (en_bits)
);

// File: tb/sim_tlu_top.sv
module sim_tlu_top;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 512;
  localparam int LANE_W = 32;
  localparam int MASK_W = DATA_W / LANE_W;
  localparam int WORDS  = DATA_W / 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [7:0]        imm8 = '0;
  logic [DATA_W-1:0] src_a = '0, src_b = '0, src_c = '0, dst_old = '0;
  logic [MASK_W-1:0] wmask = '0;
  logic              elem_wide = 1'b0, zero_mode = 1'b0, no_mask = 1'b0;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tlu_top #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm8(imm8),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .dst_old(dst_old),
    .wmask(wmask), .elem_wide(elem_wide), .zero_mode(zero_mode),
    .no_mask(no_mask), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [DATA_W-1:0] rnd_wide();
    logic [DATA_W-1:0] v;
    for (int w = 0; w < WORDS; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  // Expected result, stated bit by bit from the requirements.
  function automatic logic [DATA_W-1:0] model(
      input logic [7:0] t, input logic [DATA_W-1:0] a, b, c, d,
      input logic [MASK_W-1:0] m, input logic wide, zero, nm);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < DATA_W; k++) begin
      int  lane = wide ? k / (2*LANE_W) : k / LANE_W;
      bit  en   = nm || m[lane];
      int  idx  = a[k]*4 + b[k]*2 + c[k];
      if (en)        r[k] = t[idx];
      else if (zero) r[k] = 1'b0;
      else           r[k] = d[k];
    end
    return r;
  endfunction

  task automatic check_vec(input string req, input logic [DATA_W-1:0] got,
                           input logic [DATA_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Drive at a falling edge; the result is registered at the next rising
  // edge and sampled at the falling edge after it.
  task automatic run_op(input string req, input logic [7:0] t,
      input logic [DATA_W-1:0] a, b, c, d, input logic [MASK_W-1:0] m,
      input logic wide, zero, nm);
    logic [DATA_W-1:0] exp;
    exp = model(t, a, b, c, d, m, wide, zero, nm);
    @(negedge clk);
    in_valid = 1'b1; imm8 = t; src_a = a; src_b = b; src_c = c;
    dst_old = d; wmask = m; elem_wide = wide; zero_mode = zero; no_mask = nm;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({req, " R9 valid"}, out_valid, 1'b1);
    check_vec(req, out_data, exp);
  endtask

  initial begin
    logic [DATA_W-1:0] a, b, c, d, held;
    void'($urandom(32'd1234));
    #(CLK_P*2);
    check_bit("R11 valid reset", out_valid, 1'b0);
    check_vec("R11 data reset", out_data, '0);
    rst_n = 1'b1;

    a = rnd_wide(); b = rnd_wide(); c = rnd_wide(); d = rnd_wide();
    // R3: bit select
    run_op("R3 select", 8'hCA, a, b, c, d, '0, 1'b0, 1'b0, 1'b1);
    check_vec("R3 formula", out_data, (a & b) | (~a & c));
    // R1: single-minterm tables pick out one index pattern
    for (int t = 0; t < 8; t++)
      run_op("R1 minterm", 8'(1 << t), a, b, c, d, '1, 1'b0, 1'b0, 1'b0);
    // R4: bypass with empty mask, both sizes
    run_op("R4 bypass narrow", 8'h96, a, b, c, d, '0, 1'b0, 1'b1, 1'b1);
    run_op("R4 bypass wide", 8'h96, a, b, c, d, '0, 1'b1, 1'b0, 1'b1);
    // R6: upper mask byte ignored in wide mode
    run_op("R6 upper byte merge", 8'hFF, a, b, c, d, 16'hFF00, 1'b1, 1'b0, 1'b0);
    check_vec("R6 R7 all kept", out_data, d);
    run_op("R6 upper byte zero", 8'hFF, a, b, c, d, 16'hFF00, 1'b1, 1'b1, 1'b0);
    check_vec("R6 R8 all cleared", out_data, '0);
    run_op("R6 wide alt", 8'hE8, a, b, c, d, 16'h00A5, 1'b1, 1'b0, 1'b0);
    // R5 R7 R8: narrow alternating masks
    run_op("R5 R7 narrow merge", 8'h3C, a, b, c, d, 16'h5A5A, 1'b0, 1'b0, 1'b0);
    run_op("R5 R8 narrow zero", 8'h3C, a, b, c, d, 16'hA5A5, 1'b0, 1'b1, 1'b0);
    // R10: hold while idle, inputs scrambled
    held = out_data;
    @(negedge clk);
    src_a = rnd_wide(); dst_old = rnd_wide(); imm8 = 8'h5A; wmask = '1;
    @(negedge clk);
    check_bit("R9 idle", out_valid, 1'b0);
    check_vec("R10 hold", out_data, held);
    // R2: random sweep over every immediate and mode
    for (int i = 0; i < 400; i++) begin
      logic [31:0] sel;
      sel = $urandom;
      run_op("R2 random", 8'(i), rnd_wide(), rnd_wide(), rnd_wide(),
             rnd_wide(), MASK_W'($urandom), sel[0], sel[1], sel[2] & sel[3]);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule